// File: doc/BRIEF.md
# Address Decoder with Per-Region Delayed Acknowledge

This block sits beside a bus master. It turns the upper bits of a byte address, gated by an active-high address strobe, into one chip select per 16 KB block. The decoded window covers eight consecutive blocks starting at address zero. Block 0 holds the boot ROM, so the reset vectors are at the bottom of memory. A population mask marks which blocks are fitted. The remaining blocks are undecoded.

For every fitted block, a parameter sets the number of clocks from strobe assertion to the slave acknowledge. Slow EPROM blocks get wait states, and fast RAM acknowledges in the same cycle. The delay timer is either a shift register or a counter, chosen by a parameter. It is cleared whenever the strobe negates.

An access that is left without an acknowledge, such as one to an undecoded address, is ended by a watchdog. The watchdog raises a bus fault after a fixed number of clocks and holds it until the strobe drops.

Top module: `addr_dec_ack`

## Requirements
- R1: While `addr_stb` is high, `addr[23:17]` is zero and block i = `addr[16:14]` is fitted (bit i of the population mask), `cs` equals the one-hot value with only bit i set.
- R2: While `addr_stb` is low, `cs`, `xfer_ack` and `bus_fault` are all low, whatever the address.
- R3: An address with any bit above bit 16 set drives no chip select and never gets `xfer_ack`.
- R4: An address inside the window whose block is not fitted drives no chip select.
- R5: For a fitted block with delay d (0 to 7), `xfer_ack` is low while fewer than d rising clock edges have passed since the strobe was asserted. It is high from the d-th edge (same cycle when d is 0) until the strobe negates.
- R6: Negating the strobe restarts the delay, so a new access after one idle clock waits its full delay again.
- R7: An access to an undecoded address never produces `xfer_ack`.
- R8: `bus_fault` rises once 16 rising edges have passed with the strobe high and no acknowledge, stays high until the strobe negates, and never occurs on a fitted block.
- R9: The shift-register and counter variants of the delay timer give identical outputs cycle for cycle.
- R10: While `rst_n` is low with the strobe low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 24 | Byte address from the bus master |
| addr_stb | input | 1 | Address valid strobe, active high |
| cs | output | 8 | One-hot chip select, one bit per 16 KB block |
| xfer_ack | output | 1 | Slave acknowledge to the bus master |
| bus_fault | output | 1 | Watchdog bus error for an unacknowledged access |

## Verification
The bench builds two copies with default widths: eight 16 KB blocks, a watchdog limit of 16, and fitted blocks 0, 1, 2 and 7. These four blocks have delays of 3, 0, 5 and 7. One copy uses the shift-register timer and the other uses the counter timer. This set of values puts the zero-delay, mid-range and maximum acknowledge delays on the same sweep as unfitted blocks and addresses outside the window. As a result, every block can be visited at several offsets, and each access can be held long enough to watch the watchdog fire. Every output of both copies is compared each cycle against values the bench derives from the address fields.

// File: rtl/adk_pkg.sv
package adk_pkg;

   // Smallest field width the delay timer accepts
   localparam int unsigned ADK_MIN_DLY_W = 2;

   // Longest delay a field of the given width can express
   function automatic int unsigned adk_max_dly(input int unsigned w);
      return (32'd1 << w) - 32'd1;
   endfunction

endpackage

// File: rtl/adk_region_decode.sv
module adk_region_decode #(
   parameter int unsigned ADDR_W   = 24,
   parameter int unsigned BLK_LSB  = 14,
   parameter int unsigned NUM_BLK  = 8,
   parameter int unsigned DLY_W    = 3,
   parameter logic [NUM_BLK-1:0]       POP_MASK = '1,
   parameter logic [NUM_BLK*DLY_W-1:0] DLY_TAB  = '0
) (
   input  logic [ADDR_W-BLK_LSB-1:0] blk_addr,
   input  logic                      stb,
   output logic [NUM_BLK-1:0]        cs,
   output logic                      hit,
   output logic [DLY_W-1:0]          dly
);

   localparam int unsigned IDX_W = $clog2(NUM_BLK);
   localparam int unsigned BA_W  = ADDR_W - BLK_LSB;

   logic [IDX_W-1:0] idx;
   logic             in_win;

   assign idx    = blk_addr[IDX_W-1:0];
   assign in_win = (blk_addr[BA_W-1:IDX_W] == '0);
   assign hit    = in_win & POP_MASK[idx];
   assign dly    = DLY_TAB[idx*DLY_W +: DLY_W];

   for (genvar gi = 0; gi < NUM_BLK; gi++) begin : g_cs
      if (POP_MASK[gi]) begin : g_fitted
         assign cs[gi] = stb & in_win & (idx == IDX_W'(gi));
      end else begin : g_empty
         assign cs[gi] = 1'b0;
      end
   end

endmodule

// File: rtl/adk_wait_gen.sv
module adk_wait_gen #(
   parameter int unsigned DLY_W     = 3,
   parameter bit          USE_SHIFT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic [DLY_W-1:0] dly,
   output logic             done
);

   localparam int unsigned MAX_DLY = adk_pkg::adk_max_dly(DLY_W);

   if (USE_SHIFT) begin : g_shift
      // bit k set means at least k+1 edges have passed under the strobe
      logic [MAX_DLY-1:0] sr;
      logic [DLY_W-1:0]   tap;

      always_ff @(posedge clk) begin
         if (!rst_n)   sr <= '0;
         else if (!stb) sr <= '0;
         else          sr <= {sr[MAX_DLY-2:0], 1'b1};
      end

      assign tap  = dly - DLY_W'(1);
      assign done = (dly == '0) | sr[tap];
   end else begin : g_count
      logic [DLY_W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n)                      cnt <= '0;
         else if (!stb)                   cnt <= '0;
         else if (cnt != DLY_W'(MAX_DLY)) cnt <= cnt + DLY_W'(1);
      end

      assign done = (cnt >= dly);
   end

endmodule

// File: rtl/adk_watchdog.sv
module adk_watchdog #(
   parameter int unsigned WD_LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic acked,
   output logic expired
);

   localparam int unsigned CW = $clog2(WD_LIMIT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                                 cnt <= '0;
      else if (!stb)                              cnt <= '0;
      else if (!acked && cnt != CW'(WD_LIMIT))    cnt <= cnt + CW'(1);
   end

   assign expired = stb & (cnt == CW'(WD_LIMIT));

endmodule

// File: rtl/addr_dec_ack.sv
module addr_dec_ack #(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned BLK_LSB   = 14,
   parameter int unsigned NUM_BLK   = 8,
   parameter int unsigned DLY_W     = 3,
   parameter int unsigned WD_LIMIT  = 16,
   parameter bit          USE_SHIFT = 1'b1,
   parameter logic [NUM_BLK-1:0]       POP_MASK = 8'b1000_0111,
   parameter logic [NUM_BLK*DLY_W-1:0] DLY_TAB  =
      {3'd7, 3'd0, 3'd0, 3'd0, 3'd0, 3'd5, 3'd0, 3'd3}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               addr_stb,
   output logic [NUM_BLK-1:0] cs,
   output logic               xfer_ack,
   output logic               bus_fault
);

   localparam int unsigned IDX_W   = $clog2(NUM_BLK);
   localparam int unsigned MAX_DLY = adk_pkg::adk_max_dly(DLY_W);

   // Elaboration-time parameter checks
   if ((32'd1 << IDX_W) != NUM_BLK) begin : g_chk_blk
      $error("NUM_BLK must be a power of two");
   end
   if (ADDR_W <= BLK_LSB + IDX_W) begin : g_chk_addr
      $error("ADDR_W leaves no bits above the decoded window");
   end
   if (DLY_W < adk_pkg::ADK_MIN_DLY_W) begin : g_chk_dly
      $error("DLY_W too small");
   end
   if (WD_LIMIT <= MAX_DLY) begin : g_chk_wd
      $error("WD_LIMIT must exceed the longest acknowledge delay");
   end

   logic             hit;
   logic [DLY_W-1:0] dly;
   logic             done;
   logic             ack_raw;
   logic             expired;
   logic             unused_lo;

   assign unused_lo = ^addr[BLK_LSB-1:0];

   adk_region_decode #(
      .ADDR_W   (ADDR_W),
      .BLK_LSB  (BLK_LSB),
      .NUM_BLK  (NUM_BLK),
      .DLY_W    (DLY_W),
      .POP_MASK (POP_MASK),
      .DLY_TAB  (DLY_TAB)
   ) u_dec (
      .blk_addr (addr[ADDR_W-1:BLK_LSB]),
      .stb      (addr_stb),
      .cs       (cs),
      .hit      (hit),
      .dly      (dly)
   );

   adk_wait_gen #(
      .DLY_W     (DLY_W),
      .USE_SHIFT (USE_SHIFT)
   ) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (addr_stb),
      .dly   (dly),
      .done  (done)
   );

   assign ack_raw = addr_stb & hit & done;

   adk_watchdog #(
      .WD_LIMIT (WD_LIMIT)
   ) u_wd (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (addr_stb),
      .acked   (ack_raw),
      .expired (expired)
   );

   assign xfer_ack  = ack_raw & ~expired;
   assign bus_fault = expired;

endmodule

// File: rtl/adk_checker.sv
module adk_checker #(
   parameter int unsigned ADDR_W  = 24,
   parameter int unsigned NUM_BLK = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  addr,
   input logic               addr_stb,
   input logic [NUM_BLK-1:0] cs,
   input logic               xfer_ack,
   input logic               bus_fault
);

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs)); // R1

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_stb |-> (cs == '0 && !xfer_ack && !bus_fault)); // R2

   AST_ACK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack |-> (cs != '0)); // R7

   AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ack && addr_stb) |=> (!addr_stb || !$stable(addr) || xfer_ack)); // R5

   AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_fault && addr_stb) |=> (!addr_stb || bus_fault)); // R8

   AST_FAULT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      bus_fault |-> !xfer_ack); // R8

endmodule

bind addr_dec_ack adk_checker #(
   .ADDR_W  (ADDR_W),
   .NUM_BLK (NUM_BLK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .addr_stb  (addr_stb),
   .cs        (cs),
   .xfer_ack  (xfer_ack),
   .bus_fault (bus_fault)
);

// File: tb/addr_dec_ack_tb.sv
module addr_dec_ack_tb;

   localparam logic [7:0]  MASK = 8'b1000_0111;
   localparam logic [23:0] DTAB = {3'd7, 3'd0, 3'd0, 3'd0, 3'd0, 3'd5, 3'd0, 3'd3};
   localparam int          WDL  = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] addr = '0;
   logic        stb = 1'b0;
   logic [7:0]  cs_a, cs_b;
   logic        ack_a, ack_b, flt_a, flt_b;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   addr_dec_ack #(.USE_SHIFT(1'b1), .POP_MASK(MASK), .DLY_TAB(DTAB), .WD_LIMIT(WDL)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .addr_stb(stb),
      .cs(cs_a), .xfer_ack(ack_a), .bus_fault(flt_a));

   addr_dec_ack #(.USE_SHIFT(1'b0), .POP_MASK(MASK), .DLY_TAB(DTAB), .WD_LIMIT(WDL)) u_dut_ctr (
      .clk(clk), .rst_n(rst_n), .addr(addr), .addr_stb(stb),
      .cs(cs_b), .xfer_ack(ack_b), .bus_fault(flt_b));

   function automatic int blk_dly(input int b);
      return int'(DTAB[b*3 +: 3]);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic sample(input string tag, input string atag, input logic [7:0] ecs,
                         input logic eack, input logic eflt);
      chk(tag, "cs", {24'd0, cs_a}, {24'd0, ecs});
      chk(atag, "ack", {31'd0, ack_a}, {31'd0, eack});
      chk("R8", "fault", {31'd0, flt_a}, {31'd0, eflt});
      chk("R9", "cs ctr", {24'd0, cs_b}, {24'd0, ecs});
      chk("R9", "ack ctr", {31'd0, ack_b}, {31'd0, eack});
      chk("R9", "fault ctr", {31'd0, flt_b}, {31'd0, eflt});
   endtask

   task automatic access(input logic [23:0] a, input int ncyc, input string tag);
      int b;
      int d;
      logic hit;
      logic [7:0] ecs;
      string atag;
      b   = int'(a[16:14]);
      d   = blk_dly(b);
      hit = (a[23:17] == 7'd0) && MASK[b];
      ecs = hit ? (8'd1 << b) : 8'd0;
      atag = (tag == "R6") ? "R6" : (hit ? "R5" : "R7");
      @(negedge clk);
      addr = a;
      stb  = 1'b1;
      #1;
      sample(tag, atag, ecs, hit && (d == 0), 1'b0);
      for (int k = 1; k <= ncyc; k++) begin
         @(negedge clk);
         #1;
         sample(tag, atag, ecs, hit && (k >= d), !hit && (k >= WDL));
      end
      @(negedge clk);
      stb = 1'b0;
      #1;
      sample("R2", "R2", 8'd0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=hung exp=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [13:0] offs [3];
      offs[0] = 14'h0000;
      offs[1] = 14'h1555;
      offs[2] = 14'h3FFF;

      // R10: outputs quiet under reset
      repeat (3) @(negedge clk);
      #1;
      sample("R10", "R10", 8'd0, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 / R4: sweep every block at three offsets
      for (int b = 0; b < 8; b++) begin
         for (int o = 0; o < 3; o++) begin
            access({7'd0, 3'(b), offs[o]}, 18, MASK[b] ? "R1" : "R4");
         end
      end

      // R3: addresses above the window, some aliasing fitted blocks
      access(24'h020000, 18, "R3");
      access(24'h03C000, 18, "R3");
      access(24'h100000, 18, "R3");
      access(24'hFFFFFE, 18, "R3");

      // R6: abort a slow access early, then repeat it in full
      access(24'h008000, 2, "R6");
      access(24'h008002, 10, "R6");
      access(24'h01C000, 3, "R6");
      access(24'h01C010, 9, "R6");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule